// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block sends short messages, one bit per frame, on the monitor channels of a time-division line. It serves a set of channels arranged as several multiplexes of equal size (by default two multiplexes of eight channels). Each channel has its own serial output, and the output advances one bit on every frame tick. A host writes a 16-bit word to a chosen channel together with three control bits. The byte-count bit selects one or two bytes, the final bit marks the word as the end of a message, and the timer-enable bit arms the acknowledgement watchdog.

Each byte is shifted out, and the channel then waits for the remote receiver to acknowledge it. An acknowledgement either starts the second byte or completes the word. The remote end can abort the transfer. When the timer is enabled, the transfer also ends if an acknowledgement does not arrive within a set number of frame ticks after a byte's final bit. A transfer that completes, aborts or times out sets that channel's bit in a shared interrupt register, and a host read clears that register. A maskable summary line reports any pending channel interrupt. The host can inspect the status of a selected channel.

Top module: `monx_top`

## Requirements
- R1: The low byte of the word (bits 7:0) is sent first. The high byte (bits 15:8) follows only when `wrOneByte` was 0. With `wrOneByte` = 1 the channel goes idle after the first byte is acknowledged.
- R2: A busy channel in its shifting phase puts one bit on `txBit` per clock with `frameTick` high, most significant bit first. `txBit` changes at no other time except that it returns to 1 when a transfer ends. It is 1 after reset.
- R3: `statOut[4]` is 1 while the first byte is in progress (and after reset). It is 0 once the second byte has started.
- R4: `statOut[3]` equals the `wrLast` value written with the channel's current word.
- R5: An `abortIn` pulse on a busy channel sets `statOut[2]`, ends the transfer (`statOut[5]` busy goes to 0) and raises that channel's interrupt bit.
- R6: With `wrTimerEn` = 1, a channel that receives no acknowledgement by the TIMEOUT_TICKS-th frame tick after a byte's final bit sets `statOut[1]`, goes idle and raises its interrupt. The count restarts for each byte. With `wrTimerEn` = 0 the channel waits indefinitely.
- R7: An acknowledgement of the final byte ends the transfer, raises the interrupt and lets the channel accept a new word. An interrupt bit is never set without an acknowledge, abort or frame tick.
- R8: Channel x of multiplex y owns interrupt bit y*CH_PER_MUX + x in `intFlags`, and the bit stays set until read. A cycle with `intRd` high returns the current contents, and the register is 0 on the next cycle. It is 0 after reset.
- R9: `irqOut` is high when any interrupt bit is set and `intMask` is 0. It is always low when `intMask` is 1.
- R10: A write to a busy channel is ignored: the word on the line is unchanged. It sets the sticky flag `statOut[0]`. The next accepted write clears that flag together with the abort and timeout flags.
- R11: An interrupt event in the same cycle as `intRd` is kept and shows in `intFlags` after the clear.
- R12: Abort takes priority over acknowledge, which takes priority over timeout, when these coincide. An acknowledge during the shifting phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle pulse per frame; bit and timer step |
| wrEn | input | 1 | Host write strobe for a data word |
| wrChan | input | CH_W | Target channel of the write |
| wrWord | input | 16 | Two bytes, low byte sent first |
| wrOneByte | input | 1 | 1: send only the low byte |
| wrLast | input | 1 | Final-byte mark, mirrored in status |
| wrTimerEn | input | 1 | Enable acknowledgement timeout |
| ackIn | input | NCH | Per-channel acknowledge pulse from remote |
| abortIn | input | NCH | Per-channel abort pulse from remote |
| txBit | output | NCH | Serial line per channel, idle 1 |
| txActive | output | NCH | Channel is in shifting phase |
| statSel | input | CH_W | Channel whose status is shown |
| statOut | output | 6 | {busy, firstByte, last, aborted, timedOut, overrun} |
| intRd | input | 1 | Host read of the interrupt register (clears it) |
| intFlags | output | NCH | Per-channel interrupt bits |
| intMask | input | 1 | Blocks the summary interrupt |
| irqOut | output | 1 | Summary interrupt |

## Verification
The bench builds the block with the default two multiplexes of eight channels, so the upper interrupt half is reached through a multiplex-one channel. It sets TIMEOUT_TICKS to 4 and sends a frame tick every third clock, so a timeout arrives within about a dozen clocks of a byte's final bit. This keeps the timeout path, the timer restart per byte, and its clash with acknowledges and aborts within short directed tests and a long random phase.

// File: rtl/monx_pkg.sv
package monx_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int STAT_W = 6;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_SHIFT = 2'd1,
    CH_WAIT  = 2'd2
  } chState_e;

  // Per-channel commands from control to datapath
  typedef struct packed {
    logic load;
    logic shiftBit;
    logic nextByte;
    logic armTimer;
    logic runTimer;
    logic evDone;
    logic evAbort;
    logic evTimeout;
    logic setOverrun;
  } chStrobe_t;

endpackage

// File: rtl/monx_ctrl.sv
module monx_ctrl
  import monx_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameTick,
  input  logic            wrEn,
  input  logic [CH_W-1:0] wrChan,
  input  logic [NCH-1:0]  ackIn,
  input  logic [NCH-1:0]  abortIn,
  input  logic [NCH-1:0]  lastBit,
  input  logic [NCH-1:0]  moreByte,
  input  logic [NCH-1:0]  timerOn,
  input  logic [NCH-1:0]  timerHit,
  output chStrobe_t       strobe [NCH],
  output logic [NCH-1:0]  busy,
  output logic [NCH-1:0]  shifting
);

  for (genvar g = 0; g < NCH; g++) begin : gCh
    chState_e  st;
    chState_e  stNext;
    chStrobe_t sb;
    logic      wrHit;

    assign wrHit = wrEn && (wrChan == CH_W'(g));

    always_comb begin
      sb     = '0;
      stNext = st;
      unique case (st)
        CH_IDLE: begin
          if (wrHit) begin
            sb.load = 1'b1;
            stNext  = CH_SHIFT;
          end
        end
        CH_SHIFT: begin
          if (abortIn[g]) begin
            sb.evAbort = 1'b1;
            stNext     = CH_IDLE;
          end else if (frameTick) begin
            sb.shiftBit = 1'b1;
            if (lastBit[g]) begin
              sb.armTimer = 1'b1;
              stNext      = CH_WAIT;
            end
          end
        end
        CH_WAIT: begin
          if (abortIn[g]) begin
            sb.evAbort = 1'b1;
            stNext     = CH_IDLE;
          end else if (ackIn[g]) begin
            if (moreByte[g]) begin
              sb.nextByte = 1'b1;
              stNext      = CH_SHIFT;
            end else begin
              sb.evDone = 1'b1;
              stNext    = CH_IDLE;
            end
          end else if (frameTick && timerOn[g]) begin
            if (timerHit[g]) begin
              sb.evTimeout = 1'b1;
              stNext       = CH_IDLE;
            end else begin
              sb.runTimer = 1'b1;
            end
          end
        end
        default: stNext = CH_IDLE;
      endcase
      if (st != CH_IDLE && wrHit) sb.setOverrun = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) st <= CH_IDLE;
      else       st <= stNext;
    end

    assign strobe[g]   = sb;
    assign busy[g]     = (st != CH_IDLE);
    assign shifting[g] = (st == CH_SHIFT);
  end

endmodule

// File: rtl/monx_dpath.sv
module monx_dpath
  import monx_pkg::*;
#(
  parameter int NCH           = 16,
  parameter int CH_W          = 4,
  parameter int TIMEOUT_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wrWord,
  input  logic              wrOneByte,
  input  logic              wrLast,
  input  logic              wrTimerEn,
  input  chStrobe_t         strobe [NCH],
  input  logic [NCH-1:0]    busy,
  input  logic [CH_W-1:0]   statSel,
  input  logic              intRd,
  output logic [NCH-1:0]    lastBit,
  output logic [NCH-1:0]    moreByte,
  output logic [NCH-1:0]    timerOn,
  output logic [NCH-1:0]    timerHit,
  output logic [NCH-1:0]    txBit,
  output logic [STAT_W-1:0] statOut,
  output logic [NCH-1:0]    intFlags
);

  localparam int TMR_W = $clog2(TIMEOUT_TICKS + 1);

  logic [STAT_W-1:0] chStat [NCH];
  logic [NCH-1:0]    evVec;

  for (genvar g = 0; g < NCH; g++) begin : gCh
    chStrobe_t         sb;
    logic [WORD_W-1:0] word;
    logic              oneByte;
    logic              lastFlag;
    logic              timerEn;
    logic              byteSel;
    logic [BIT_W-1:0]  bitCnt;
    logic [TMR_W-1:0]  tmr;
    logic              tx;
    logic              aborted;
    logic              timedOut;
    logic              overrun;
    logic [BYTE_W-1:0] curByte;
    logic              bitNow;

    assign sb      = strobe[g];
    assign curByte = byteSel ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
    assign bitNow  = curByte[BIT_W'(BYTE_W-1) - bitCnt];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        word     <= '0;
        oneByte  <= 1'b0;
        lastFlag <= 1'b0;
        timerEn  <= 1'b0;
        byteSel  <= 1'b0;
        bitCnt   <= '0;
        tmr      <= '0;
        tx       <= 1'b1;
        aborted  <= 1'b0;
        timedOut <= 1'b0;
        overrun  <= 1'b0;
      end else begin
        if (sb.load) begin
          word     <= wrWord;
          oneByte  <= wrOneByte;
          lastFlag <= wrLast;
          timerEn  <= wrTimerEn;
          byteSel  <= 1'b0;
          bitCnt   <= '0;
          aborted  <= 1'b0;
          timedOut <= 1'b0;
          overrun  <= 1'b0;
        end
        if (sb.shiftBit) begin
          tx     <= bitNow;
          bitCnt <= bitCnt + 1'b1;
        end
        if (sb.nextByte) begin
          byteSel <= 1'b1;
          bitCnt  <= '0;
        end
        if (sb.armTimer)      tmr <= '0;
        else if (sb.runTimer) tmr <= tmr + 1'b1;
        if (sb.evDone || sb.evAbort || sb.evTimeout) tx <= 1'b1;
        if (sb.evAbort)    aborted  <= 1'b1;
        if (sb.evTimeout)  timedOut <= 1'b1;
        if (sb.setOverrun) overrun  <= 1'b1;
      end
    end

    assign lastBit[g]  = (bitCnt == BIT_W'(BYTE_W - 1));
    assign moreByte[g] = !byteSel && !oneByte;
    assign timerOn[g]  = timerEn;
    assign timerHit[g] = (tmr == TMR_W'(TIMEOUT_TICKS - 1));
    assign txBit[g]    = tx;
    assign evVec[g]    = sb.evDone | sb.evAbort | sb.evTimeout;
    assign chStat[g]   = {busy[g], ~byteSel, lastFlag, aborted, timedOut, overrun};
  end

  assign statOut = chStat[statSel];

  always_ff @(posedge clk) begin
    if (!rstN) intFlags <= '0;
    else       intFlags <= (intRd ? '0 : intFlags) | evVec;
  end

endmodule

// File: rtl/monx_top.sv
module monx_top
  import monx_pkg::*;
#(
  parameter int MUX_COUNT     = 2,
  parameter int CH_PER_MUX    = 8,
  parameter int TIMEOUT_TICKS = 8,
  localparam int NCH  = MUX_COUNT * CH_PER_MUX,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [15:0]       wrWord,
  input  logic              wrOneByte,
  input  logic              wrLast,
  input  logic              wrTimerEn,
  input  logic [NCH-1:0]    ackIn,
  input  logic [NCH-1:0]    abortIn,
  output logic [NCH-1:0]    txBit,
  output logic [NCH-1:0]    txActive,
  input  logic [CH_W-1:0]   statSel,
  output logic [5:0]        statOut,
  input  logic              intRd,
  output logic [NCH-1:0]    intFlags,
  input  logic              intMask,
  output logic              irqOut
);

  chStrobe_t      strobe [NCH];
  logic [NCH-1:0] busy;
  logic [NCH-1:0] lastBit;
  logic [NCH-1:0] moreByte;
  logic [NCH-1:0] timerOn;
  logic [NCH-1:0] timerHit;

  monx_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .wrEn(wrEn), .wrChan(wrChan),
    .ackIn(ackIn), .abortIn(abortIn),
    .lastBit(lastBit), .moreByte(moreByte),
    .timerOn(timerOn), .timerHit(timerHit),
    .strobe(strobe), .busy(busy), .shifting(txActive)
  );

  monx_dpath #(.NCH(NCH), .CH_W(CH_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_dpath (
    .clk(clk), .rstN(rstN),
    .wrWord(wrWord), .wrOneByte(wrOneByte), .wrLast(wrLast), .wrTimerEn(wrTimerEn),
    .strobe(strobe), .busy(busy), .statSel(statSel), .intRd(intRd),
    .lastBit(lastBit), .moreByte(moreByte), .timerOn(timerOn), .timerHit(timerHit),
    .txBit(txBit), .statOut(statOut), .intFlags(intFlags)
  );

  assign irqOut = (|intFlags) & ~intMask;

endmodule

// File: rtl/monx_chk.sv
module monx_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           frameTick,
  input logic           intRd,
  input logic           intMask,
  input logic [NCH-1:0] ackIn,
  input logic [NCH-1:0] abortIn,
  input logic [NCH-1:0] txBit,
  input logic [NCH-1:0] intFlags,
  input logic           irqOut
);

  // R2: the line only moves on a frame tick or when a transfer ends
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!frameTick && ackIn == '0 && abortIn == '0) |=> $stable(txBit));

  // R7: no interrupt bit appears without a triggering input
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!frameTick && ackIn == '0 && abortIn == '0) |=> ((intFlags & ~$past(intFlags)) == '0));

  // R8: bits stay set while no read happens
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !intRd |=> ((intFlags & $past(intFlags)) == $past(intFlags)));

  // R8: a read with no concurrent event leaves the register empty
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intRd && !frameTick && ackIn == '0 && abortIn == '0) |=> (intFlags == '0));

  // R9: the mask always silences the summary line
  assert_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    intMask |-> !irqOut);

endmodule

bind monx_top monx_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .frameTick(frameTick), .intRd(intRd), .intMask(intMask),
  .ackIn(ackIn), .abortIn(abortIn), .txBit(txBit), .intFlags(intFlags), .irqOut(irqOut)
);

// File: tb/monx_top_tb.sv
module monx_top_tb;

  localparam int NCH = 16;
  localparam int TO  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrChan = '0;
  logic [15:0] wrWord = '0;
  logic        wrOneByte = 1'b0, wrLast = 1'b0, wrTimerEn = 1'b0;
  logic [15:0] ackIn = '0, abortIn = '0;
  logic [15:0] txBit, txActive, intFlags;
  logic [3:0]  statSel = '0;
  logic [5:0]  statOut;
  logic        intRd = 1'b0, intMask = 1'b0, irqOut;

  monx_top #(.MUX_COUNT(2), .CH_PER_MUX(8), .TIMEOUT_TICKS(TO)) u_dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .wrEn(wrEn), .wrChan(wrChan),
    .wrWord(wrWord), .wrOneByte(wrOneByte), .wrLast(wrLast), .wrTimerEn(wrTimerEn),
    .ackIn(ackIn), .abortIn(abortIn), .txBit(txBit), .txActive(txActive),
    .statSel(statSel), .statOut(statOut), .intRd(intRd), .intFlags(intFlags),
    .intMask(intMask), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // frame tick every third clock while enabled
  logic tickGate = 1'b0;
  int   tickDiv = 0;
  always @(posedge clk) begin
    #5;
    tickDiv   = (tickDiv + 1) % 3;
    frameTick = tickGate && (tickDiv == 0);
  end

  // behavioural reference: 0 idle, 1 sending bits, 2 awaiting acknowledge
  int          mSt[NCH], mCnt[NCH], mTmr[NCH], mSel[NCH];
  logic [15:0] mWord[NCH];
  bit          mOne[NCH], mLast[NCH], mTen[NCH], mTx[NCH], mAb[NCH], mTo[NCH], mOv[NCH];
  logic [15:0] mInt, ev;
  int          prevSt;
  bit          hit;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mSt[c] = 0; mCnt[c] = 0; mTmr[c] = 0; mSel[c] = 0; mWord[c] = '0;
        mOne[c] = 0; mLast[c] = 0; mTen[c] = 0; mTx[c] = 1; mAb[c] = 0; mTo[c] = 0; mOv[c] = 0;
      end
      mInt = '0;
    end else begin
      ev = '0;
      for (int c = 0; c < NCH; c++) begin
        hit    = wrEn && (int'(wrChan) == c);
        prevSt = mSt[c];
        if (mSt[c] == 0) begin
          if (hit) begin
            mWord[c] = wrWord; mOne[c] = wrOneByte; mLast[c] = wrLast; mTen[c] = wrTimerEn;
            mSel[c] = 0; mCnt[c] = 0; mAb[c] = 0; mTo[c] = 0; mOv[c] = 0; mSt[c] = 1;
          end
        end else if (abortIn[c]) begin
          mAb[c] = 1; mSt[c] = 0; mTx[c] = 1; ev[c] = 1;
        end else if (mSt[c] == 1) begin
          if (frameTick) begin
            mTx[c] = mWord[c][mSel[c]*8 + 7 - mCnt[c]];
            if (mCnt[c] == 7) begin mCnt[c] = 0; mSt[c] = 2; mTmr[c] = 0; end
            else mCnt[c]++;
          end
        end else begin
          if (ackIn[c]) begin
            if (mSel[c] == 0 && !mOne[c]) begin mSel[c] = 1; mCnt[c] = 0; mSt[c] = 1; end
            else begin mSt[c] = 0; mTx[c] = 1; ev[c] = 1; end
          end else if (frameTick && mTen[c]) begin
            if (mTmr[c] == TO - 1) begin mTo[c] = 1; mSt[c] = 0; mTx[c] = 1; ev[c] = 1; end
            else mTmr[c]++;
          end
        end
        if (prevSt != 0 && hit) mOv[c] = 1;
      end
      mInt = (intRd ? 16'h0 : mInt) | ev;
    end
  end

  // per-clock comparison against the reference
  logic [15:0] eTx, eAct;
  logic [5:0]  eStat;
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < NCH; c++) begin
        eTx[c]  = mTx[c];
        eAct[c] = (mSt[c] == 1);
      end
      eStat = {mSt[statSel] != 0, mSel[statSel] == 0, mLast[statSel],
               mAb[statSel], mTo[statSel], mOv[statSel]};
      chk(txBit == eTx, "R2", "txBit vs model", 32'(txBit), 32'(eTx));
      chk(txActive == eAct, "R1", "txActive vs model", 32'(txActive), 32'(eAct));
      chk(intFlags == mInt, "R8", "intFlags vs model", 32'(intFlags), 32'(mInt));
      chk(irqOut == ((mInt != 0) && !intMask), "R9", "irqOut vs model", 32'(irqOut),
          32'((mInt != 0) && !intMask));
      chk(statOut == eStat, "R3 R4 R5 R6 R10", "statOut vs model", 32'(statOut), 32'(eStat));
    end
  end

  // capture of one channel's serial bits
  int          capCh = 0, capN = 0;
  logic [15:0] cap = '0;
  bit          lastTick = 0, lastAct = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (lastTick && lastAct) begin
        cap = {cap[14:0], txBit[capCh]};
        capN++;
      end
      lastTick = frameTick;
      lastAct  = txActive[capCh];
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic writeWord(input int ch, input logic [15:0] w, input bit one, input bit lst, input bit ten);
    wrEn = 1; wrChan = 4'(ch); wrWord = w; wrOneByte = one; wrLast = lst; wrTimerEn = ten;
    step();
    wrEn = 0;
  endtask

  task automatic startCap(input int ch);
    capCh = ch; capN = 0; cap = '0;
  endtask

  task automatic waitCap(input int n);
    for (int i = 0; i < 400 && capN < n; i++) step();
  endtask

  task automatic pulseAck(input int ch);
    ackIn[ch] = 1; step(); ackIn = '0;
  endtask

  task automatic pulseAbort(input int ch);
    abortIn[ch] = 1; step(); abortIn = '0;
  endtask

  initial begin
    step(3);
    rstN = 1;
    step();
    // reset state
    chk(txBit == 16'hFFFF, "R2", "idle line after reset", 32'(txBit), 32'hFFFF);
    chk(txActive == 16'h0, "R2", "no channel active after reset", 32'(txActive), 0);
    chk(intFlags == 16'h0, "R8", "flags zero after reset", 32'(intFlags), 0);
    chk(statOut == 6'b010000, "R3", "status after reset", 32'(statOut), 32'h10);
    tickGate = 1;

    // two-byte word on channel 3
    statSel = 4'd3;
    startCap(3);
    writeWord(3, 16'hA5C3, 0, 1, 0);
    waitCap(8);
    step(2);
    chk(cap[7:0] == 8'hC3, "R1", "low byte first, MSB first (R2)", 32'(cap[7:0]), 32'hC3);
    chk(statOut[4] == 1'b1, "R3", "first byte progress", 32'(statOut[4]), 1);
    chk(statOut[3] == 1'b1, "R4", "last mirror set", 32'(statOut[3]), 1);
    pulseAck(3);
    waitCap(16);
    chk(cap[7:0] == 8'hA5, "R1", "high byte second", 32'(cap[7:0]), 32'hA5);
    chk(statOut[4] == 1'b0, "R3", "second byte progress", 32'(statOut[4]), 0);
    chk(intFlags[3] == 1'b0, "R7", "no interrupt before final ack", 32'(intFlags[3]), 0);
    pulseAck(3);
    chk(intFlags == 16'h0008, "R7", "done interrupt", 32'(intFlags), 32'h8);
    chk(statOut[5] == 1'b0, "R7", "channel idle after done", 32'(statOut[5]), 0);
    chk(irqOut == 1'b1, "R9", "summary raised", 32'(irqOut), 1);
    intMask = 1;
    step();
    chk(irqOut == 1'b0, "R9", "summary masked", 32'(irqOut), 0);
    intMask = 0;
    intRd = 1;
    chk(intFlags == 16'h0008, "R8", "read returns contents", 32'(intFlags), 32'h8);
    step();
    intRd = 0;
    chk(intFlags == 16'h0, "R8", "cleared after read", 32'(intFlags), 0);

    // one-byte word on multiplex 1, channel 4 (bit 12)
    statSel = 4'd12;
    startCap(12);
    writeWord(12, 16'h7E81, 1, 0, 0);
    chk(statOut[3] == 1'b0, "R4", "last mirror clear", 32'(statOut[3]), 0);
    waitCap(8);
    chk(cap[7:0] == 8'h81, "R1", "single byte sent", 32'(cap[7:0]), 32'h81);
    step(2);
    pulseAck(12);
    chk(intFlags == 16'h1000, "R8", "multiplex 1 channel 4 bit", 32'(intFlags), 32'h1000);
    step(12);
    chk(txActive[12] == 1'b0, "R1", "no high byte in one-byte mode", 32'(txActive[12]), 0);

    // overrun on channel 5, then abort
    statSel = 4'd5;
    startCap(5);
    writeWord(5, 16'h1234, 0, 0, 0);
    writeWord(5, 16'hFFFF, 1, 1, 0);
    chk(statOut[0] == 1'b1, "R10", "overrun flag set", 32'(statOut[0]), 1);
    waitCap(8);
    chk(cap[7:0] == 8'h34, "R10", "busy write ignored", 32'(cap[7:0]), 32'h34);
    pulseAbort(5);
    chk(statOut[2] == 1'b1, "R5", "abort flag", 32'(statOut[2]), 1);
    chk(statOut[5] == 1'b0, "R5", "idle after abort", 32'(statOut[5]), 0);
    chk(intFlags[5] == 1'b1, "R5", "abort interrupt", 32'(intFlags[5]), 1);
    writeWord(5, 16'h00AA, 1, 0, 0);
    chk(statOut[2:0] == 3'b000, "R10", "flags cleared on accepted write", 32'(statOut[2:0]), 0);
    pulseAbort(5);

    // timeout on channel 7
    statSel = 4'd7;
    startCap(7);
    writeWord(7, 16'h00F0, 1, 1, 1);
    waitCap(8);
    step(4);
    chk(statOut[1] == 1'b0, "R6", "no timeout yet", 32'(statOut[1]), 0);
    step(16);
    chk(statOut[1] == 1'b1, "R6", "timeout flag", 32'(statOut[1]), 1);
    chk(intFlags[7] == 1'b1, "R6", "timeout interrupt", 32'(intFlags[7]), 1);

    // timer disabled on channel 8
    statSel = 4'd8;
    writeWord(8, 16'h0055, 1, 0, 0);
    step(80);
    chk(statOut[5:4] == 2'b11 && statOut[1] == 1'b0, "R6", "no timeout when disabled",
        32'(statOut), 32'h30);
    pulseAbort(8);

    // event coinciding with a read on channel 9
    startCap(9);
    writeWord(9, 16'h0003, 1, 0, 0);
    waitCap(8);
    step(1);
    ackIn[9] = 1; intRd = 1;
    step();
    ackIn = '0; intRd = 0;
    chk(intFlags == 16'h0200, "R11", "event kept across read", 32'(intFlags), 32'h200);

    // priority: abort with ack on channel 10
    statSel = 4'd10;
    startCap(10);
    writeWord(10, 16'h000F, 1, 0, 1);
    waitCap(8);
    ackIn[10] = 1; abortIn[10] = 1;
    step();
    ackIn = '0; abortIn = '0;
    chk(statOut[2] == 1'b1, "R12", "abort wins over ack", 32'(statOut[2]), 1);

    // ack during shifting ignored on channel 11
    statSel = 4'd11;
    startCap(11);
    writeWord(11, 16'h00C6, 1, 0, 0);
    waitCap(2);
    pulseAck(11);
    chk(statOut[5] == 1'b1 && txActive[11] == 1'b1, "R12", "ack while shifting ignored",
        32'({statOut[5], txActive[11]}), 32'h3);
    waitCap(8);
    chk(cap[7:0] == 8'hC6, "R12", "byte intact after early ack", 32'(cap[7:0]), 32'hC6);
    step(2);
    pulseAbort(11);

    // random phase checked by the reference each clock
    for (int i = 0; i < 3000; i++) begin
      wrEn      = ($urandom % 4) == 0;
      wrChan    = 4'($urandom);
      wrWord    = 16'($urandom);
      wrOneByte = 1'($urandom);
      wrLast    = 1'($urandom);
      wrTimerEn = ($urandom % 4) != 0;
      ackIn     = 16'($urandom) & 16'($urandom) & 16'($urandom);
      abortIn   = 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom);
      intRd     = ($urandom % 16) == 0;
      intMask   = ($urandom % 8) == 0;
      statSel   = 4'($urandom);
      step();
    end
    wrEn = 0; ackIn = '0; abortIn = '0; intRd = 0; intMask = 0;
    step(4);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule